// File: doc/BRIEF.md
# UV-Erasable PROM Functional Core

This block is a clocked, synthesizable model of a byte-wide electrically programmable read-only memory whose contents can be cleared only by a full erase. The array holds 2048 bytes behind an 11-bit address. The bidirectional data bus is split into three signals: a byte input, a byte output and an output-drive qualifier. The control pins are an active-low chip enable that also serves as the program pulse, an active-low output enable, and a flag that reports whether the programming supply sits at its raised level.

All control and data inputs are sampled on the rising clock edge. The output byte and its drive qualifier are registered, so they reflect the inputs one cycle after they are sampled. A read always returns the array contents from before that edge's update. Programming can only clear bits: the new word is the old word ANDed with the presented byte. An erase input stands in for ultraviolet exposure and returns every location to all ones. Reset also leaves the array in that erased state.

Top module: `eprom_core`

## Requirements
- R1: After reset, and with no programming since, every location reads 8'hFF. While reset is held, `dataOe`, `illegal` and `dataOut` are all 0.
- R2: With `vppHigh`=0, `ceN`=0 and `oeN`=0 sampled on an edge, `dataOe` is 1 after that edge and `dataOut` holds the byte stored at `addr` before that edge.
- R3: Whenever `dataOe` is 0, `dataOut` is 8'h00. With `vppHigh`=0, `ceN`=0 and `oeN`=1, the outputs are not driven.
- R4: With `vppHigh`=0 and `ceN`=1 (standby), the outputs are not driven, whatever the value of `oeN`.
- R5: With `vppHigh`=1 and `oeN`=1, an edge that samples `ceN`=1 after the previous edge sampled `ceN`=0 replaces the addressed word with (old AND `dataIn`). Holding `ceN` high writes nothing further. The edge-detect history resets to "high", so a strobe already high when reset is released writes nothing.
- R6: A program operation never turns a 0 bit back into 1.
- R7: No location changes in program inhibit (`vppHigh`=1, `oeN`=1, `ceN`=0), nor on a `ceN` rise while `vppHigh`=0. Locations other than the addressed one never change on a write.
- R8: With `vppHigh`=1, `ceN`=0 and `oeN`=0 (verify), `dataOe` is 1 after the edge and `dataOut` holds the stored byte.
- R9: With `vppHigh`=1, `ceN`=1 and `oeN`=0, `illegal` is 1 after the edge and the outputs are not driven. A later rise of `oeN` while `ceN` stays high writes nothing.
- R10: An edge that samples `eraseAll`=1 sets every location to 8'hFF. Erase takes priority over a program strobe sampled on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset; leaves the array erased |
| addr | input | 11 | Word address |
| dataIn | input | 8 | Byte presented for programming |
| ceN | input | 1 | Active-low chip enable; its rising edge is the program pulse |
| oeN | input | 1 | Active-low output enable |
| vppHigh | input | 1 | 1 when the programming supply is at its raised level |
| eraseAll | input | 1 | Bulk erase to all ones |
| dataOut | output | 8 | Registered read byte, 0 when not driven |
| dataOe | output | 1 | 1 when the data bus would be driven |
| illegal | output | 1 | 1 after an edge that sampled the forbidden verify-while-pulsing state |

## Verification
Two operations can land on the same edge: a program strobe and a bulk erase, or a read and an erase of the location being read. The bench raises `ceN` at the same edge that samples `eraseAll`, then verifies that the target still reads 8'hFF, which shows the erase won. It also reads a programmed address on the erase edge and expects the old byte, then expects 8'hFF on the following cycle.

// File: rtl/eprom_pkg.sv
package eprom_pkg;

  typedef enum logic [2:0] {
    MODE_READ,
    MODE_STANDBY,
    MODE_PROGRAM,
    MODE_INHIBIT,
    MODE_VERIFY,
    MODE_ILLEGAL
  } eprom_mode_e;

  // strobes handed from control to datapath
  typedef struct packed {
    logic wrStb;
    logic eraseStb;
    logic rdEn;
  } eprom_ctrl_t;

endpackage

// File: rtl/eprom_ctrl.sv
module eprom_ctrl
  import eprom_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ceN,
  input  logic        oeN,
  input  logic        vppHigh,
  input  logic        eraseAll,
  output eprom_ctrl_t strb,
  output logic        dataOe,
  output logic        illegal
);

  eprom_mode_e mode;
  logic        prevCeN;
  logic        pgmRise;

  always_comb begin
    if (!vppHigh) begin
      mode = ceN ? MODE_STANDBY : MODE_READ;
    end else if (oeN) begin
      mode = ceN ? MODE_PROGRAM : MODE_INHIBIT;
    end else begin
      mode = ceN ? MODE_ILLEGAL : MODE_VERIFY;
    end
  end

  // program pulse is the low-to-high transition on the chip-enable pin
  assign pgmRise = (mode == MODE_PROGRAM) && !prevCeN;

  always_comb begin
    strb.eraseStb = eraseAll;
    strb.wrStb    = pgmRise && !eraseAll;
    strb.rdEn     = ((mode == MODE_READ) && !oeN) || (mode == MODE_VERIFY);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prevCeN <= 1'b1;
      dataOe  <= 1'b0;
      illegal <= 1'b0;
    end else begin
      prevCeN <= ceN;
      dataOe  <= strb.rdEn;
      illegal <= (mode == MODE_ILLEGAL);
    end
  end

endmodule

// File: rtl/eprom_array.sv
module eprom_array
  import eprom_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  eprom_ctrl_t       strb,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] rdData
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [DATA_W-1:0] ERASED = {DATA_W{1'b1}};

  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= ERASED;
    end else if (strb.eraseStb) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= ERASED;
    end else if (strb.wrStb) begin
      cells[addr] <= cells[addr] & dataIn;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdData <= '0;
    end else begin
      rdData <= strb.rdEn ? cells[addr] : '0;
    end
  end

endmodule

// File: rtl/eprom_core.sv
module eprom_core
  import eprom_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              ceN,
  input  logic              oeN,
  input  logic              vppHigh,
  input  logic              eraseAll,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe,
  output logic              illegal
);

  eprom_ctrl_t strb;

  eprom_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .ceN      (ceN),
    .oeN      (oeN),
    .vppHigh  (vppHigh),
    .eraseAll (eraseAll),
    .strb     (strb),
    .dataOe   (dataOe),
    .illegal  (illegal)
  );

  eprom_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .clk    (clk),
    .rst_n  (rst_n),
    .strb   (strb),
    .addr   (addr),
    .dataIn (dataIn),
    .rdData (dataOut)
  );

endmodule

// File: rtl/eprom_core_chk.sv
module eprom_core_chk #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              ceN,
  input logic              oeN,
  input logic              vppHigh,
  input logic              eraseAll,
  input logic [DATA_W-1:0] dataOut,
  input logic              dataOe,
  input logic              illegal
);

  assert_read_drives_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!vppHigh && !ceN && !oeN) |=> dataOe);

  assert_idle_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !dataOe |-> (dataOut == '0));

  assert_standby_float_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!vppHigh && ceN) |=> !dataOe);

  assert_verify_drives_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (vppHigh && !ceN && !oeN) |=> dataOe);

  assert_illegal_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (vppHigh && ceN && !oeN) |=> (illegal && !dataOe));

  assert_illegal_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(illegal && dataOe));

  assert_erase_reads_ones_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (eraseAll ##1 (!vppHigh && !ceN && !oeN && !eraseAll)) |=> (dataOut == '1));

endmodule

bind eprom_core eprom_core_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .addr     (addr),
  .ceN      (ceN),
  .oeN      (oeN),
  .vppHigh  (vppHigh),
  .eraseAll (eraseAll),
  .dataOut  (dataOut),
  .dataOe   (dataOe),
  .illegal  (illegal)
);

// File: tb/sim_eprom_core.sv
module sim_eprom_core;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [10:0] addr;
  logic [7:0]  dataIn;
  logic        ceN, oeN, vppHigh, eraseAll;
  logic [7:0]  dataOut;
  logic        dataOe, illegal;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  eprom_core u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .dataIn(dataIn),
    .ceN(ceN), .oeN(oeN), .vppHigh(vppHigh), .eraseAll(eraseAll),
    .dataOut(dataOut), .dataOe(dataOe), .illegal(illegal)
  );

  typedef struct packed {
    logic       vpp;
    logic       ce;
    logic       oe;
    logic       er;
    logic [10:0] a;
    logic [7:0] d;
    logic       xOe;
    logic [7:0] xOut;
    logic       xIll;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 25;
  localparam vec_t VEC [NV] = '{
    '{1'b0,1'b0,1'b0,1'b0,11'h000,8'h00, 1'b1,8'hFF,1'b0, 4'd1},  // R1 erased low
    '{1'b0,1'b0,1'b0,1'b0,11'h7FF,8'h00, 1'b1,8'hFF,1'b0, 4'd1},  // R1 erased top
    '{1'b1,1'b0,1'b1,1'b0,11'h005,8'hA5, 1'b0,8'h00,1'b0, 4'd7},  // R7 inhibit
    '{1'b1,1'b1,1'b1,1'b0,11'h005,8'hA5, 1'b0,8'h00,1'b0, 4'd5},  // R5 rise writes
    '{1'b1,1'b1,1'b1,1'b0,11'h005,8'h00, 1'b0,8'h00,1'b0, 4'd5},  // R5 held high
    '{1'b1,1'b0,1'b1,1'b0,11'h005,8'h00, 1'b0,8'h00,1'b0, 4'd7},  // R7 inhibit
    '{1'b1,1'b0,1'b0,1'b0,11'h005,8'h00, 1'b1,8'hA5,1'b0, 4'd8},  // R8 verify
    '{1'b0,1'b0,1'b0,1'b0,11'h005,8'h00, 1'b1,8'hA5,1'b0, 4'd2},  // R2 read
    '{1'b0,1'b0,1'b1,1'b0,11'h005,8'h00, 1'b0,8'h00,1'b0, 4'd3},  // R3 oe high
    '{1'b0,1'b1,1'b0,1'b0,11'h005,8'h00, 1'b0,8'h00,1'b0, 4'd4},  // R4 standby
    '{1'b1,1'b1,1'b0,1'b0,11'h005,8'h00, 1'b0,8'h00,1'b1, 4'd9},  // R9 illegal
    '{1'b1,1'b0,1'b1,1'b0,11'h005,8'h5A, 1'b0,8'h00,1'b0, 4'd7},  // R7 inhibit
    '{1'b1,1'b1,1'b1,1'b0,11'h005,8'h5A, 1'b0,8'h00,1'b0, 4'd6},  // R6 A5&5A
    '{1'b1,1'b0,1'b1,1'b0,11'h005,8'hFF, 1'b0,8'h00,1'b0, 4'd7},  // R7 inhibit
    '{1'b1,1'b0,1'b0,1'b0,11'h005,8'hFF, 1'b1,8'h00,1'b0, 4'd6},  // R6 stays 00
    '{1'b0,1'b0,1'b0,1'b0,11'h006,8'h00, 1'b1,8'hFF,1'b0, 4'd7},  // R7 neighbour
    '{1'b0,1'b0,1'b0,1'b1,11'h005,8'h00, 1'b1,8'h00,1'b0, 4'd10}, // R10 old data
    '{1'b0,1'b0,1'b0,1'b0,11'h005,8'h00, 1'b1,8'hFF,1'b0, 4'd10}, // R10 erased
    '{1'b1,1'b0,1'b1,1'b0,11'h010,8'h00, 1'b0,8'h00,1'b0, 4'd7},  // R7 inhibit
    '{1'b1,1'b1,1'b0,1'b0,11'h010,8'h00, 1'b0,8'h00,1'b1, 4'd9},  // R9 illegal rise
    '{1'b1,1'b1,1'b1,1'b0,11'h010,8'h00, 1'b0,8'h00,1'b0, 4'd9},  // R9 oe rises
    '{1'b1,1'b0,1'b0,1'b0,11'h010,8'h00, 1'b1,8'hFF,1'b0, 4'd9},  // R9 no write
    '{1'b1,1'b0,1'b1,1'b0,11'h020,8'h00, 1'b0,8'h00,1'b0, 4'd7},  // R7 inhibit
    '{1'b1,1'b1,1'b1,1'b1,11'h020,8'h00, 1'b0,8'h00,1'b0, 4'd10}, // R10 erase+rise
    '{1'b1,1'b0,1'b0,1'b0,11'h020,8'h00, 1'b1,8'hFF,1'b0, 4'd10}  // R10 erase wins
  };

  task automatic drive(input logic v, input logic c, input logic o, input logic e,
                       input logic [10:0] a, input logic [7:0] d);
    @(negedge clk);
    vppHigh = v; ceN = c; oeN = o; eraseAll = e; addr = a; dataIn = d;
    @(posedge clk);
    #2;
  endtask

  task automatic check(input logic xo, input logic [7:0] xd, input logic xi,
                       input int req, input string what);
    checks++;
    if (dataOe !== xo || dataOut !== xd || illegal !== xi) begin
      fails++;
      $display("FAIL R%0d %s: oe=%b out=%h ill=%b expected oe=%b out=%h ill=%b",
               req, what, dataOe, dataOut, illegal, xo, xd, xi);
    end
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; vppHigh = 1'b0; ceN = 1'b1; oeN = 1'b1; eraseAll = 1'b0;
    addr = '0; dataIn = '0;
    repeat (3) @(posedge clk);
    #2;
    check(1'b0, 8'h00, 1'b0, 1, "held in reset");  // R1
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i].vpp, VEC[i].ce, VEC[i].oe, VEC[i].er, VEC[i].a, VEC[i].d);
      check(VEC[i].xOe, VEC[i].xOut, VEC[i].xIll, int'(VEC[i].req), "vector");
    end

    // R5: strobe already high across reset release must not write
    @(negedge clk);
    rst_n = 1'b0; vppHigh = 1'b1; ceN = 1'b1; oeN = 1'b1; addr = 11'h030; dataIn = 8'h00;
    @(negedge clk);
    rst_n = 1'b1;
    drive(1'b1, 1'b1, 1'b1, 1'b0, 11'h030, 8'h00);
    drive(1'b1, 1'b0, 1'b0, 1'b0, 11'h030, 8'h00);
    check(1'b1, 8'hFF, 1'b0, 5, "high strobe at reset release");

    // R5: proper pulse programs 0x030 to 0x3C
    drive(1'b1, 1'b0, 1'b1, 1'b0, 11'h030, 8'h3C);
    drive(1'b1, 1'b1, 1'b1, 1'b0, 11'h030, 8'h3C);
    drive(1'b1, 1'b0, 1'b0, 1'b0, 11'h030, 8'h00);
    check(1'b1, 8'h3C, 1'b0, 5, "pulse programs");

    // R7: ce rise with normal supply writes nothing
    drive(1'b0, 1'b0, 1'b1, 1'b0, 11'h031, 8'h00);
    drive(1'b0, 1'b1, 1'b1, 1'b0, 11'h031, 8'h00);
    drive(1'b0, 1'b0, 1'b0, 1'b0, 11'h031, 8'h00);
    check(1'b1, 8'hFF, 1'b0, 7, "rise without high supply");

    // R1: reset returns the array to erased
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    drive(1'b0, 1'b0, 1'b0, 1'b0, 11'h030, 8'h00);
    check(1'b1, 8'hFF, 1'b0, 1, "erased after reset");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule